// File: doc/BRIEF.md
# Operand Packing Unit

This unit assembles a 64-bit result out of selected fields of two source operands, `rs1_i` and `rs2_i`. A 3-bit operation code picks one of five placement rules. Two rules work on full-width halves. One joins the two low bytes. Two word rules build a 32-bit value out of 16-bit fields and then sign-extend it to the full datapath width. The unit is purely combinational, so it can sit in an execute stage beside the other integer functions. The result is due in the same cycle as its operands.

Codes that name no rule produce an all-zero result and raise `illegal_o`. The upstream decoder can use that flag to raise an exception. The datapath width is a parameter. The two word rules exist only when that width is 64. At any other width their codes are treated as unused.

Top module: `opk_unit`

## Requirements
- R1: With code 0 (half pack), result bits 31:0 equal rs1 bits 31:0 and result bits 63:32 equal rs2 bits 31:0.
- R2: With code 1 (upper pack), result bits 31:0 equal rs1 bits 63:32 and result bits 63:32 equal rs2 bits 63:32.
- R3: With code 2 (byte pack), result bits 7:0 equal rs1 bits 7:0, result bits 15:8 equal rs2 bits 7:0, and result bits 63:16 are zero.
- R4: With code 3 (word pack), result bits 15:0 equal rs1 bits 15:0, result bits 31:16 equal rs2 bits 15:0, and every bit in 63:32 equals rs2 bit 15.
- R5: With code 4 (word upper pack), result bits 15:0 equal rs1 bits 31:16, result bits 31:16 equal rs2 bits 31:16, and every bit in 63:32 equals rs2 bit 31.
- R6: Codes 5, 6 and 7 drive a result of zero and set `illegal_o` to 1, whatever the operands are. Codes 0 to 4 hold `illegal_o` at 0.
- R7: The result depends only on the current inputs. Changing the operands or the code changes the output with no clock edge, and earlier inputs leave no trace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rs1_i | input | 64 | First source operand |
| rs2_i | input | 64 | Second source operand |
| op_i | input | 3 | Placement rule select (0 to 4 legal) |
| result_o | output | 64 | Packed result |
| illegal_o | output | 1 | High when op_i names no rule |

## Verification
Every result and the illegal flag are combinational, so they are due zero cycles after a stimulus, once the inputs settle. The bench changes inputs only on the falling clock edge. It samples two nanoseconds later, well before the next rising edge, so each check sees settled values from the current inputs alone. For R7, two stimuli are applied in turn with no rising edge between them, and each one is checked in its own window.

// File: rtl/opk_pkg.sv
package opk_pkg;

  // Operation codes; the numeric values are the external encoding.
  typedef enum logic [2:0] {
    OPK_HALF_LO = 3'd0,
    OPK_HALF_HI = 3'd1,
    OPK_BYTES   = 3'd2,
    OPK_WORD_LO = 3'd3,
    OPK_WORD_HI = 3'd4
  } opk_op_e;

  localparam int unsigned OPK_OP_W = 3;

  // One-hot rule select produced by the decoder.
  typedef struct packed {
    logic word_hi;
    logic word_lo;
    logic bytes;
    logic half_hi;
    logic half_lo;
  } opk_sel_t;

endpackage

// File: rtl/opk_decode.sv
module opk_decode
  import opk_pkg::*;
#(
  parameter bit HAS_WORD = 1'b1
) (
  input  logic [OPK_OP_W-1:0] op_i,
  output opk_sel_t            sel_o,
  output logic                illegal_o
);

  always_comb begin
    sel_o = '0;
    case (op_i)
      OPK_HALF_LO: sel_o.half_lo = 1'b1;
      OPK_HALF_HI: sel_o.half_hi = 1'b1;
      OPK_BYTES:   sel_o.bytes   = 1'b1;
      OPK_WORD_LO: sel_o.word_lo = HAS_WORD;
      OPK_WORD_HI: sel_o.word_hi = HAS_WORD;
      default:     sel_o = '0;
    endcase
  end

  assign illegal_o = (sel_o == '0);

  always_comb begin
    // R6
    unused_code_chk: assert (!(op_i > 3'd4) || illegal_o)
      else $error("code %0d not flagged illegal", op_i);
    // R6
    legal_code_chk: assert (!(op_i <= 3'd2) || !illegal_o)
      else $error("code %0d flagged illegal", op_i);
    // R6
    one_rule_chk: assert ($onehot0(sel_o))
      else $error("more than one rule selected");
  end

endmodule

// File: rtl/opk_full_pack.sv
module opk_full_pack #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic [XLEN-1:0] half_lo_o,
  output logic [XLEN-1:0] half_hi_o,
  output logic [XLEN-1:0] bytes_o
);

  localparam int unsigned HALF = XLEN / 2;
  localparam int unsigned BYTE = 8;

  function automatic logic [XLEN-1:0] join_low_halves(
    input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return {b[HALF-1:0], a[HALF-1:0]};
  endfunction

  function automatic logic [XLEN-1:0] join_high_halves(
    input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return {b[XLEN-1:HALF], a[XLEN-1:HALF]};
  endfunction

  function automatic logic [XLEN-1:0] join_low_bytes(
    input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return {{(XLEN-2*BYTE){1'b0}}, b[BYTE-1:0], a[BYTE-1:0]};
  endfunction

  assign half_lo_o = join_low_halves(rs1_i, rs2_i);
  assign half_hi_o = join_high_halves(rs1_i, rs2_i);
  assign bytes_o   = join_low_bytes(rs1_i, rs2_i);

endmodule

// File: rtl/opk_word_pack.sv
module opk_word_pack #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WORD = 32
) (
  input  logic [WORD-1:0] rs1_w_i,
  input  logic [WORD-1:0] rs2_w_i,
  output logic [XLEN-1:0] word_lo_o,
  output logic [XLEN-1:0] word_hi_o
);

  localparam int unsigned HW  = WORD / 2;
  localparam int unsigned EXT = XLEN - WORD;

  function automatic logic [XLEN-1:0] widen_signed(input logic [WORD-1:0] w);
    return {{EXT{w[WORD-1]}}, w};
  endfunction

  function automatic logic [WORD-1:0] join_low_quarters(
    input logic [WORD-1:0] a, input logic [WORD-1:0] b);
    return {b[HW-1:0], a[HW-1:0]};
  endfunction

  function automatic logic [WORD-1:0] join_high_quarters(
    input logic [WORD-1:0] a, input logic [WORD-1:0] b);
    return {b[WORD-1:HW], a[WORD-1:HW]};
  endfunction

  logic [WORD-1:0] lo_word, hi_word;

  assign lo_word   = join_low_quarters(rs1_w_i, rs2_w_i);
  assign hi_word   = join_high_quarters(rs1_w_i, rs2_w_i);
  assign word_lo_o = widen_signed(lo_word);
  assign word_hi_o = widen_signed(hi_word);

endmodule

// File: rtl/opk_unit.sv
module opk_unit
  import opk_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]     rs1_i,
  input  logic [XLEN-1:0]     rs2_i,
  input  logic [OPK_OP_W-1:0] op_i,
  output logic [XLEN-1:0]     result_o,
  output logic                illegal_o
);

  localparam bit          HAS_WORD = (XLEN == 64);
  localparam int unsigned WORD     = 32;
  localparam int unsigned HALF     = XLEN / 2;

  opk_sel_t        sel;
  logic            dec_illegal;
  logic [XLEN-1:0] half_lo_val, half_hi_val, bytes_val;
  logic [XLEN-1:0] word_lo_val, word_hi_val;

  opk_decode #(.HAS_WORD(HAS_WORD)) u_decode (
    .op_i      (op_i),
    .sel_o     (sel),
    .illegal_o (dec_illegal)
  );

  opk_full_pack #(.XLEN(XLEN)) u_full (
    .rs1_i     (rs1_i),
    .rs2_i     (rs2_i),
    .half_lo_o (half_lo_val),
    .half_hi_o (half_hi_val),
    .bytes_o   (bytes_val)
  );

  generate
    if (HAS_WORD) begin : g_word
      opk_word_pack #(.XLEN(XLEN), .WORD(WORD)) u_word (
        .rs1_w_i   (rs1_i[WORD-1:0]),
        .rs2_w_i   (rs2_i[WORD-1:0]),
        .word_lo_o (word_lo_val),
        .word_hi_o (word_hi_val)
      );
    end else begin : g_no_word
      assign word_lo_val = '0;
      assign word_hi_val = '0;
    end
  endgenerate

  // AND-OR select: an empty select yields zero for unused codes.
  always_comb begin
    result_o = ({XLEN{sel.half_lo}} & half_lo_val)
             | ({XLEN{sel.half_hi}} & half_hi_val)
             | ({XLEN{sel.bytes}}   & bytes_val)
             | ({XLEN{sel.word_lo}} & word_lo_val)
             | ({XLEN{sel.word_hi}} & word_hi_val);
  end

  assign illegal_o = dec_illegal;

  always_comb begin
    // R6
    illegal_zero_chk: assert (!illegal_o || (result_o == '0))
      else $error("illegal code produced nonzero result");
    // R1
    half_lo_src_chk: assert (!(op_i == 3'd0) ||
                             (result_o[HALF-1:0] == rs1_i[HALF-1:0]))
      else $error("half pack low field mismatch");
    // R2
    half_hi_src_chk: assert (!(op_i == 3'd1) ||
                             (result_o[XLEN-1:HALF] == rs2_i[XLEN-1:HALF]))
      else $error("upper pack high field mismatch");
    // R3
    bytes_clear_chk: assert (!(op_i == 3'd2) || (result_o[XLEN-1:16] == '0))
      else $error("byte pack left high bits set");
  end

  generate
    if (HAS_WORD) begin : g_word_chk
      always_comb begin
        // R4
        word_lo_ext_chk: assert (!(op_i == 3'd3) ||
          ($countones(result_o[XLEN-1:WORD-1]) == 0) ||
          ($countones(result_o[XLEN-1:WORD-1]) == XLEN-WORD+1))
          else $error("word pack extension broken");
        // R5
        word_hi_ext_chk: assert (!(op_i == 3'd4) ||
          ($countones(result_o[XLEN-1:WORD-1]) == 0) ||
          ($countones(result_o[XLEN-1:WORD-1]) == XLEN-WORD+1))
          else $error("word upper pack extension broken");
      end
    end
  endgenerate

endmodule

// File: tb/opk_unit_tb.sv
module opk_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] rs1, rs2;
  logic [2:0]  op;
  logic [63:0] result;
  logic        illegal;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  opk_unit u_dut (
    .rs1_i     (rs1),
    .rs2_i     (rs2),
    .op_i      (op),
    .result_o  (result),
    .illegal_o (illegal)
  );

  localparam int NV = 8;
  localparam logic [63:0] TV_A [NV] = '{
    64'h1122334455667788, 64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF,
    64'h8000000080008080, 64'h7FFF7FFF7FFF7F7F, 64'hDEADBEEFCAFEF00D,
    64'h0123456789ABCDEF, 64'hA5A5A5A55A5A5A5A };
  localparam logic [63:0] TV_B [NV] = '{
    64'h99AABBCCDDEEFF00, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000,
    64'h7FFFFFFF7FFF7F7F, 64'h8000000080008080, 64'h0F1E2D3C4B5A6978,
    64'hFEDCBA9876543210, 64'h3C3C3C3CC3C3C3C3 };

  // Reference built from masks and arithmetic shifts.
  function automatic logic [63:0] ref_model(input logic [63:0] a,
                                            input logic [63:0] b,
                                            input logic [2:0]  c);
    logic [63:0] t;
    case (c)
      3'd0: return (a & 64'h00000000FFFFFFFF) | (b << 32);
      3'd1: return (a >> 32) | (b & 64'hFFFFFFFF00000000);
      3'd2: return (a & 64'hFF) | ((b & 64'hFF) << 8);
      3'd3: begin
        t = b << 48;
        return 64'($signed(t) >>> 32) | (a & 64'hFFFF);
      end
      3'd4: begin
        t = ((a >> 16) & 64'hFFFF) | (b & 64'hFFFF0000);
        t = t << 32;
        return 64'($signed(t) >>> 32);
      end
      default: return 64'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic [2:0] c);
    @(negedge clk);
    rs1 = a; rs2 = b; op = c;
    #2;
  endtask

  initial begin
    rs1 = '0; rs2 = '0; op = 3'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    // Reset-time state: zero operands, code 0 (R1, R6)
    check("R1 reset result", result, 64'h0);
    check("R6 reset flag", {63'h0, illegal}, 64'h0);

    // Table walk: every vector under every code
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < 8; c++) begin
        apply(TV_A[v], TV_B[v], 3'(c));
        check(tag_of(3'(c)), result, ref_model(TV_A[v], TV_B[v], 3'(c)));
        check("R6 flag", {63'h0, illegal}, {63'h0, (c > 4)});
      end
    end

    // Directed hand-computed values
    apply(64'h1122334455667788, 64'h99AABBCCDDEEFF00, 3'd0);
    check("R1 directed", result, 64'hDDEEFF0055667788);
    apply(64'h1122334455667788, 64'h99AABBCCDDEEFF00, 3'd1);
    check("R2 directed", result, 64'h99AABBCC11223344);
    apply(64'h1122334455667788, 64'h99AABBCCDDEEFF00, 3'd2);
    check("R3 directed", result, 64'h0000000000000088);
    apply(64'h1122334455667788, 64'h99AABBCCDDEEFF00, 3'd3);
    check("R4 directed negative", result, 64'hFFFFFFFFFF007788);
    apply(64'h1122334455667788, 64'h0000000000007F00, 3'd3);
    check("R4 directed positive", result, 64'h000000007F007788);
    apply(64'h1122334455667788, 64'h99AABBCCDDEEFF00, 3'd4);
    check("R5 directed negative", result, 64'hFFFFFFFFDDEE5566);
    apply(64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFF7FFFFFFF, 3'd4);
    check("R5 directed positive", result, 64'h000000007FFFFFFF);
    apply(64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 3'd7);
    check("R6 all-ones operands", result, 64'h0);
    check("R6 flag code 7", {63'h0, illegal}, 64'h1);

    // R7: two stimuli with no rising edge between them
    @(negedge clk);
    rs1 = 64'hAAAA_BBBB_CCCC_DDDD; rs2 = 64'h1111_2222_3333_4444; op = 3'd1;
    #1;
    check("R7 first", result, 64'h11112222AAAABBBB);
    rs1 = 64'h0; rs2 = 64'h0000_0000_0000_00FF; op = 3'd2;
    #1;
    check("R7 second", result, 64'h000000000000FF00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
    end
  end

endmodule